// File: doc/BRIEF.md
# Selectless SPI Receiver with Pattern Resynchronisation

This block is the receiving end of a three-wire SPI link that has no select line. It runs SPI mode 0 and samples SCK and MOSI in a faster system clock. There is no select line to mark where a transfer begins, so the block looks at the most recent sixteen received bits after every rising SCK edge and compares them with a fixed start pattern. The pattern is a run of eight ones followed by eight zeros. When the pattern is found, the block records how far into its free-running bit count the pattern ended. It then cuts every later byte at that same point. A byte boundary that has drifted because of a glitch on SCK, or because the master started early, is therefore corrected by the next start pattern.

A byte only becomes certain once the block knows it was not the start of a new frame. For this reason the received bytes are held back. A byte is released when the second byte after it completes. Bytes still held when a start pattern is found are dropped. As a result, the trailing dummy byte that the master sends at the end of a transfer is never output, and neither are the two pattern bytes.

For replies, software loads a byte, and the block shifts it out on MISO, most significant bit first, during the next byte slot. MISO changes on falling SCK edges. When no reply is loaded, MISO sends all ones.

Top module: `selectless_spi_rx`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `rx_valid`, `resync` and `aligned` are 0, `phase` is 0 and `miso` is 1.
- R2: SCK and MOSI pass through two flip-flops into `clk`. MOSI is captured on each rising SCK edge (mode 0). SCK may run at no more than a quarter of the `clk` rate.
- R3: The start pattern is 16'hFF00 on the wire, first bit most significant. It is recognised at any bit alignment. It sets `aligned`, which then stays set until reset. It loads `phase` with the number of rising SCK edges since reset, modulo 8.
- R4: `rx_valid` stays low until the first start pattern has been recognised.
- R5: After a start pattern, each group of 8 rising edges forms one byte, first bit received in bit 7. A released byte is shown on `rx_data` with a one-cycle `rx_valid` pulse.
- R6: A byte is released when the second byte after it completes. Bytes still held when a start pattern completes are discarded. So a transfer of N data bytes, a dummy byte and the next start pattern yields exactly the N data bytes.
- R7: `resync` pulses for one cycle when a start pattern completes while `aligned` is set and the new phase differs from `phase`. It stays low on the first lock and on a pattern at the same phase.
- R8: After a spurious extra SCK edge, the next start pattern moves `phase` by one, and the data bytes that follow it come out intact.
- R9: A byte written with `tx_load` is driven on `miso` during the byte slot that follows the next byte boundary, MSB first, changing on falling SCK edges. Every other slot, including all time before the first lock, drives ones.
- R10: Reset clears the partial bit window, so half of a start pattern sent before reset and half sent after it does not produce a lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCK |
| rst | input | 1 | Synchronous reset, active high |
| sck | input | 1 | Serial clock from the master, idles low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial reply data to the master |
| tx_load | input | 1 | One-cycle strobe that stores `tx_data` as the next reply |
| tx_data | input | W | Reply byte |
| rx_valid | output | 1 | One-cycle strobe for a released byte |
| rx_data | output | W | Released, realigned byte |
| resync | output | 1 | One-cycle strobe when the frame phase changes |
| aligned | output | 1 | A start pattern has been seen since reset |
| phase | output | $clog2(W) | Bit count at which the last start pattern ended |

## Verification
The assertions assume that SCK stays at each level for several system clocks. Under that assumption, two byte boundaries can never fall in adjacent cycles, and a released byte and a phase change can never share a cycle. They also assume that data bytes never form the start pattern by accident. The bench meets both assumptions. It holds each SCK level for six clocks, and it builds every data and dummy byte with bit 3 cleared, so no run of eight ones can appear outside a start pattern.

// File: rtl/selectless_spi_rx.sv
module selectless_spi_rx #(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sck,
  input  logic                 mosi,
  output logic                 miso,
  input  logic                 tx_load,
  input  logic [W-1:0]         tx_data,
  output logic                 rx_valid,
  output logic [W-1:0]         rx_data,
  output logic                 resync,
  output logic                 aligned,
  output logic [$clog2(W)-1:0] phase
);
  localparam int CW = $clog2(W);
  localparam logic [2*W-1:0] PAT = {{W{1'b1}}, {W{1'b0}}};

  logic [2:0]     sck_p;
  logic [1:0]     mosi_p;
  logic [2*W-1:0] win;
  logic [CW-1:0]  cnt;
  logic [W-1:0]   q0, q1, tsr, reply;
  logic [1:0]     qn;
  logic           reply_ok, load_next;

  wire rise = sck_p[1] & ~sck_p[2];
  wire fall = ~sck_p[1] & sck_p[2];
  wire [2*W-1:0] win_n = {win[2*W-2:0], mosi_p[1]};
  wire [CW-1:0]  cnt_n = (cnt == CW'(W-1)) ? '0 : cnt + 1'b1;
  wire hit  = rise & (win_n == PAT);
  wire slot = rise & aligned & (cnt_n == phase);
  wire done = slot & ~hit;

  assign miso = tsr[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p  <= '0;
      mosi_p <= '0;
    end else begin
      sck_p  <= {sck_p[1:0], sck};
      mosi_p <= {mosi_p[0], mosi};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win <= '0; cnt <= '0; phase <= '0; aligned <= 1'b0;
      resync <= 1'b0; rx_valid <= 1'b0; rx_data <= '0;
      q0 <= '0; q1 <= '0; qn <= '0;
    end else begin
      rx_valid <= 1'b0;
      resync   <= 1'b0;
      if (rise) begin
        win <= win_n;
        cnt <= cnt_n;
      end
      if (hit) begin
        aligned <= 1'b1;
        phase   <= cnt_n;
        resync  <= aligned & (cnt_n != phase);
        qn      <= '0;
      end else if (done) begin
        if (qn == 2'd2) begin
          rx_valid <= 1'b1;
          rx_data  <= q0;
          q0       <= q1;
          q1       <= win_n[W-1:0];
        end else if (qn == 2'd1) begin
          q1 <= win_n[W-1:0];
          qn <= 2'd2;
        end else begin
          q0 <= win_n[W-1:0];
          qn <= 2'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tsr <= '1; reply <= '0; reply_ok <= 1'b0; load_next <= 1'b0;
    end else begin
      if (rise) load_next <= hit | slot;
      if (fall) begin
        if (load_next) begin
          tsr <= reply_ok ? reply : '1;
          reply_ok <= 1'b0;
        end else begin
          tsr <= {tsr[W-2:0], 1'b1};
        end
      end
      if (tx_load) begin
        reply    <= tx_data;
        reply_ok <= 1'b1;
      end
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!aligned && !rx_valid && !resync && miso));
  assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    aligned |=> aligned);
  assert_no_valid_unlocked_R4: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> aligned);
  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  assert_resync_moves_phase_R7: assert property (@(posedge clk) disable iff (rst)
    resync |-> (phase != $past(phase)));
  assert_resync_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_valid, resync}));
  assert_idle_miso_R9: assert property (@(posedge clk) disable iff (rst)
    !aligned |-> miso);
endmodule

// File: tb/sim_selectless_spi_rx.sv
module sim_selectless_spi_rx;
  logic clk = 0;
  always #4 clk = ~clk;

  logic rst = 1, sck = 0, mosi = 0, tx_load = 0;
  logic [7:0] tx_data = 0;
  logic miso, rx_valid, resync, aligned;
  logic [7:0] rx_data;
  logic [2:0] phase;

  selectless_spi_rx #(.W(8)) u0 (
    .clk(clk), .rst(rst), .sck(sck), .mosi(mosi), .miso(miso),
    .tx_load(tx_load), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_data(rx_data), .resync(resync), .aligned(aligned), .phase(phase)
  );

  int checks = 0, errors = 0, edges = 0;
  int nlog = 0, nres = 0, mark = 0;
  bit finished = 0;
  logic [7:0] log_q [0:255];

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        if (nlog < 256) log_q[nlog] = rx_data;
        nlog++;
      end
      if (resync) begin
        nres++;
        mark = nlog;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1; sck = 0; mosi = 0;
    repeat (4) @(negedge clk);
    nlog = 0; nres = 0; mark = 0; edges = 0;
    rst = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input logic mexp, input bit chk);
    @(negedge clk) mosi = b;
    repeat (5) @(negedge clk);
    if (chk) check(miso === mexp, "R9", miso, mexp);
    @(negedge clk) sck = 1; edges++;
    repeat (6) @(negedge clk);
    sck = 0;
  endtask

  task automatic send_byte(input logic [7:0] v, input logic [7:0] m, input bit chk);
    for (int i = 7; i >= 0; i--) send_bit(v[i], m[i], chk);
  endtask

  task automatic load_reply(input logic [7:0] v);
    @(negedge clk) tx_data = v; tx_load = 1;
    @(negedge clk) tx_load = 0;
  endtask

  function automatic logic [7:0] dat(input int s, input int i);
    return 8'((s * 53 + i * 29 + 7) & 8'hF7);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(aligned === 0 && rx_valid === 0 && resync === 0, "R1 in reset", {aligned, rx_valid, resync}, 0);
    check(miso === 1, "R1 miso in reset", miso, 1);
    do_reset();
    check(aligned === 0 && rx_valid === 0 && resync === 0, "R1 after reset", {aligned, rx_valid, resync}, 0);
    check(phase === 0 && miso === 1, "R1 phase miso", {phase, miso}, 1);

    // R3 R4 R5 R6 R9: every bit offset
    for (int k = 0; k < 8; k++) begin
      logic [7:0] rep;
      rep = 8'hA0 + 8'(k * 7);
      do_reset();
      load_reply(rep);
      for (int i = 0; i < k; i++) send_bit(1'b0, 1'b1, 1);
      send_byte(8'hFF, 8'hFF, 1);
      check(aligned === 0, "R3 no early lock", aligned, 0);
      send_byte(8'h00, 8'hFF, 1);
      check(aligned === 1, "R3 lock", aligned, 1);
      check(phase === 3'(edges % 8) && phase === 3'(k), "R3 phase", phase, k);
      check(nlog == 0, "R4 nothing before lock", nlog, 0);
      for (int j = 0; j < 4; j++) send_byte(dat(k, j), (j == 0) ? rep : 8'hFF, 1);
      send_byte(dat(k, 9), 8'hFF, 1);
      send_byte(8'hFF, 8'hFF, 1);
      send_byte(8'h00, 8'hFF, 1);
      repeat (10) @(negedge clk);
      check(nlog == 4, "R6 byte count", nlog, 4);
      for (int j = 0; j < 4; j++)
        check(log_q[j] === dat(k, j), "R2 R5 data", log_q[j], dat(k, j));
      check(nres == 0, "R7 no resync same phase", nres, 0);
      check(phase === 3'(k), "R3 phase kept", phase, k);
    end

    // R7 R8: spurious edge then realign
    do_reset();
    for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b1, 0);
    send_byte(8'hFF, 8'hFF, 0);
    send_byte(8'h00, 8'hFF, 0);
    check(nres == 0, "R7 first lock no resync", nres, 0);
    for (int j = 0; j < 3; j++) send_byte(dat(20, j), 8'hFF, 0);
    send_bit(1'b0, 1'b1, 0);
    send_byte(dat(20, 8), 8'hFF, 0);
    send_byte(8'hFF, 8'hFF, 0);
    send_byte(8'h00, 8'hFF, 0);
    repeat (10) @(negedge clk);
    check(nres == 1, "R7 resync pulse", nres, 1);
    check(phase === 3'(edges % 8) && phase === 3'd4, "R8 new phase", phase, 4);
    for (int j = 0; j < 4; j++) send_byte(dat(21, j), 8'hFF, 0);
    send_byte(dat(21, 9), 8'hFF, 0);
    send_byte(8'hFF, 8'hFF, 0);
    send_byte(8'h00, 8'hFF, 0);
    repeat (10) @(negedge clk);
    check(nres == 1, "R7 single resync", nres, 1);
    check(nlog - mark == 4, "R8 realigned count", nlog - mark, 4);
    for (int j = 0; j < 4; j++)
      check(log_q[mark + j] === dat(21, j), "R8 realigned data", log_q[mark + j], dat(21, j));

    // R10: pattern split across reset
    do_reset();
    send_byte(8'hFF, 8'hFF, 1);
    check(aligned === 0, "R10 no lock on ones", aligned, 0);
    do_reset();
    check(aligned === 0, "R1 reset clears lock", aligned, 0);
    send_byte(8'h00, 8'hFF, 1);
    for (int j = 0; j < 3; j++) send_byte(dat(30, j), 8'hFF, 1);
    repeat (10) @(negedge clk);
    check(aligned === 0, "R10 split pattern", aligned, 0);
    check(nlog == 0, "R4 R10 no output", nlog, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule